// File: doc/BRIEF.md
# Quadrature Phase Error Detector

This block measures how far apart in phase two square waves are, with a quarter period as the reference. One wave marks the zero crossings of an inverter's output voltage. The other marks those of the resonant capacitor voltage. Both inputs arrive from outside the clock domain, so each one is first resynchronised. The two synchronised bits are then exclusive-ORed. The resulting duty ratio is averaged by a first-order recursive low-pass filter that updates on every clock.

The filter state is an unsigned fraction in which full scale stands for an XOR that is high all the time. A controller that runs a slower loop asserts a sample strobe. On that strobe the block registers a signed error word, the filter level minus one half, and raises a valid flag. A zero error means the two voltages are in quadrature, which puts the inverter current in phase with its voltage. A positive error means the phase difference is more than a quarter period. A negative error means it is less.

The default shift of 14 gives a filter time constant of 16384 clocks, about 65.5 µs at 250 MHz. That is close to the intended 68 µs. The sample strobe is expected roughly every 200 µs.

Top module: `phase_quad_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the filter level to one half (0x8000 for 16 bits), clears `err_out` to 0 and drops `err_valid`. A strobe at the first edge after reset therefore reports an error of exactly 0.
- R2: Each zero-crossing input passes through a two-flop synchroniser. An input change made before edge e first affects the filter update at edge e+2, so the level it produces is first seen by a strobe at edge e+3.
- R3: The phase bit is `zc_inv` XOR `zc_cap`, after synchronisation. The filter target is full scale (0xFFFF) when the bits differ and 0 when they are equal. Held differing inputs settle the level at 0xFFFF − (2^SHIFT − 1), which reports +32752 with SHIFT = 4.
- R4: Outside reset the level updates on every edge as level + floor((target − level) / 2^SHIFT), with an arithmetic (flooring) shift. A high phase bit never lowers the level, and a low one never raises it.
- R5: The level never leaves [0, 0xFFFF]. Held equal inputs drive it to exactly 0, which reports −32768.
- R6: When `sample_tick` is high at an edge, `err_out` takes (level before that edge) − 0x8000 as a 17-bit two's complement value, and `err_valid` is high in the following cycle.
- R7: Without a strobe, `err_out` keeps its last captured value.
- R8: Strobes on consecutive edges keep `err_valid` high on each of the following cycles, and each cycle carries a fresh capture.
- R9: The output stage has two states. WAIT has `err_valid` low. EMIT has `err_valid` high. WAIT→EMIT happens on a strobe, EMIT→EMIT on a further strobe, and EMIT→WAIT when there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_inv | input | 1 | Zero-crossing square wave of the inverter output voltage (asynchronous) |
| zc_cap | input | 1 | Zero-crossing square wave of the resonant capacitor voltage (asynchronous) |
| sample_tick | input | 1 | Control sample strobe, one cycle per sample, in the `clk` domain |
| err_out | output | FRAC_W+1 (17) | Signed phase error: filtered duty minus one half |
| err_valid | output | 1 | High for the cycle after each strobe |

## Verification
An input edge reaches the filter after two synchroniser flops. It changes the level on the third clock edge after it is applied. A strobe at edge e shows its capture and `err_valid` one register later, just after edge e. The bench drives inputs on the falling edge. It advances a behavioural model at each rising edge and compares `err_out` and `err_valid` 1 ns after that edge, on every clock. Directed checks count those same edges: they place a strobe on the edge at which a new input has not yet reached the level, and then on the next edge, at which it has.

// File: rtl/pqd_pkg.sv
package pqd_pkg;

    // Output stage states: WAIT holds the last error, EMIT presents a new one.
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

    // Target level of the averaging filter for a given phase bit.
    function automatic logic [31:0] duty_target(input logic phase, input int unsigned frac_w);
        logic [31:0] full;
        full = (32'd1 << frac_w) - 32'd1;
        return phase ? full : 32'd0;
    endfunction

endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
    parameter int N_BITS = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] din,
    output logic [N_BITS-1:0] dout
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[i]};
            end
        end

        assign dout[i] = chain_q[LAST];
    end

endmodule

// File: rtl/duty_lpf.sv
module duty_lpf
    import pqd_pkg::*;
#(
    parameter int FRAC_W = 16,
    parameter int SHIFT  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_in,
    output logic [FRAC_W-1:0] level
);

    localparam int                DIFF_W = FRAC_W + 1;
    localparam logic [FRAC_W-1:0] HALF   = FRAC_W'(1) << (FRAC_W - 1);

    logic [FRAC_W-1:0]        level_q;
    logic [FRAC_W-1:0]        level_d;
    logic [FRAC_W-1:0]        target;
    logic signed [DIFF_W-1:0] diff_s;
    logic signed [DIFF_W-1:0] step_s;
    logic signed [DIFF_W-1:0] sum_s;

    always_comb begin
        target  = FRAC_W'(duty_target(phase_in, FRAC_W));
        diff_s  = $signed({1'b0, target}) - $signed({1'b0, level_q});
        step_s  = diff_s >>> SHIFT;
        sum_s   = $signed({1'b0, level_q}) + step_s;
        level_d = FRAC_W'(sum_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= HALF;
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/err_sampler.sv
module err_sampler
    import pqd_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic [FRAC_W-1:0]        level,
    output logic signed [FRAC_W:0]   err_out,
    output logic                     err_valid
);

    localparam int                      ERR_W  = FRAC_W + 1;
    localparam logic signed [ERR_W-1:0] HALF_S = ERR_W'(1) << (FRAC_W - 1);

    emit_state_t              state_q;
    emit_state_t              state_d;
    logic signed [ERR_W-1:0]  err_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (tick)  state_d = ST_EMIT;
            ST_EMIT: if (!tick) state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: capture on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (tick) begin
            err_q <= $signed({1'b0, level}) - HALF_S;
        end
    end

    assign err_out   = err_q;
    assign err_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/phase_quad_detector.sv
module phase_quad_detector
    import pqd_pkg::*;
#(
    parameter int FRAC_W      = 16,
    parameter int SHIFT       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   zc_inv,
    input  logic                   zc_cap,
    input  logic                   sample_tick,
    output logic signed [FRAC_W:0] err_out,
    output logic                   err_valid
);

    localparam int N_IN = 2;

    logic [N_IN-1:0]   zc_raw;
    logic [N_IN-1:0]   zc_sync_w;
    logic              phase_bit;
    logic [FRAC_W-1:0] level_q;

    assign zc_raw = {zc_cap, zc_inv};

    zc_sync #(
        .N_BITS (N_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (zc_raw),
        .dout (zc_sync_w)
    );

    assign phase_bit = zc_sync_w[0] ^ zc_sync_w[1];

    duty_lpf #(
        .FRAC_W (FRAC_W),
        .SHIFT  (SHIFT)
    ) u_lpf (
        .clk      (clk),
        .rst      (rst),
        .phase_in (phase_bit),
        .level    (level_q)
    );

    err_sampler #(
        .FRAC_W (FRAC_W)
    ) u_samp (
        .clk       (clk),
        .rst       (rst),
        .tick      (sample_tick),
        .level     (level_q),
        .err_out   (err_out),
        .err_valid (err_valid)
    );

endmodule

// File: rtl/pqd_checker.sv
module pqd_checker #(
    parameter int FRAC_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sample_tick,
    input logic                   err_valid,
    input logic signed [FRAC_W:0] err_out,
    input logic [FRAC_W-1:0]      filt_q,
    input logic                   phase_bit
);

    localparam int                      ERR_W  = FRAC_W + 1;
    localparam logic [FRAC_W-1:0]       HALF   = FRAC_W'(1) << (FRAC_W - 1);
    localparam logic signed [ERR_W-1:0] HALF_S = ERR_W'(1) << (FRAC_W - 1);

    assert_reset_half_R1: assert property (@(posedge clk)
        rst |=> (filt_q == HALF && !err_valid && err_out == '0));

    assert_valid_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        sample_tick |=> err_valid);

    assert_capture_value_R6: assert property (@(posedge clk) disable iff (rst)
        sample_tick |=> (err_out == ($signed({1'b0, $past(filt_q)}) - HALF_S)));

    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> ($stable(err_out) && !err_valid));

    assert_rise_when_high_R4: assert property (@(posedge clk) disable iff (rst)
        phase_bit |=> (filt_q >= $past(filt_q)));

    assert_fall_when_low_R4: assert property (@(posedge clk) disable iff (rst)
        !phase_bit |=> (filt_q <= $past(filt_q)));

endmodule

bind phase_quad_detector pqd_checker #(.FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_tick (sample_tick),
    .err_valid   (err_valid),
    .err_out     (err_out),
    .filt_q      (level_q),
    .phase_bit   (phase_bit)
);

// File: tb/tb_phase_quad_detector.sv
module tb_phase_quad_detector;

    localparam int FRAC_W = 16;
    localparam int SHIFT  = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   zc_inv = 1'b0;
    logic                   zc_cap = 1'b0;
    logic                   sample_tick = 1'b0;
    logic signed [FRAC_W:0] err_out;
    logic                   err_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    phase_quad_detector #(.FRAC_W(FRAC_W), .SHIFT(SHIFT), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .zc_inv(zc_inv), .zc_cap(zc_cap),
        .sample_tick(sample_tick), .err_out(err_out), .err_valid(err_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_inv1, m_inv2, m_cap1, m_cap2;
    int m_lvl, m_err, m_vld;
    always @(posedge clk) begin
        int tgt;
        if (rst) begin
            m_inv1 = 0; m_inv2 = 0; m_cap1 = 0; m_cap2 = 0;
            m_lvl = 32768; m_err = 0; m_vld = 0;
        end else begin
            tgt = (m_inv2 != m_cap2) ? 65535 : 0;
            if (sample_tick) begin
                m_err = m_lvl - 32768;
                m_vld = 1;
            end else begin
                m_vld = 0;
            end
            m_lvl = m_lvl + ((tgt - m_lvl) >>> SHIFT);
            m_inv2 = m_inv1; m_inv1 = int'(zc_inv);
            m_cap2 = m_cap1; m_cap1 = int'(zc_cap);
        end
    end

    // Per-cycle comparison, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check(int'(err_out) == m_err, "R4 R6 err_out vs model", int'(err_out), m_err);
            check(int'(err_valid) == m_vld, "R8 R9 err_valid vs model", int'(err_valid), m_vld);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_and_check(input string req, input int exp);
        @(negedge clk);
        sample_tick = 1'b1;
        @(posedge clk); #1;
        check(int'(err_out) == exp, req, int'(err_out), exp);
        check(err_valid == 1'b1, req, int'(err_valid), 1);
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(err_valid == 1'b0, "R1 valid low in reset", int'(err_valid), 0);
        check(int'(err_out) == 0, "R1 err zero in reset", int'(err_out), 0);

        // R1: strobe on first edge after reset sees the half level
        @(negedge clk);
        rst = 1'b0;
        sample_tick = 1'b1;
        @(posedge clk); #1;
        check(int'(err_out) == 0, "R1 first strobe error", int'(err_out), 0);
        check(err_valid == 1'b1, "R1 first strobe valid", int'(err_valid), 1);
        @(negedge clk);
        sample_tick = 1'b0;
        @(posedge clk); #1;
        check(err_valid == 1'b0, "R9 EMIT to WAIT", int'(err_valid), 0);

        // R5: equal inputs drain the level to 0
        zc_inv = 1'b1; zc_cap = 1'b1;
        cycles(600);
        tick_and_check("R5 equal inputs floor", -32768);

        // R3: differing inputs settle at full scale minus (2^SHIFT - 1)
        zc_cap = 1'b0;
        cycles(600);
        tick_and_check("R3 differing inputs ceiling", 32752);

        // R2 / R8 / R7: latency, back-to-back strobes, hold
        zc_cap = 1'b1;
        cycles(600);
        @(negedge clk);
        zc_cap = 1'b0;               // applied before edge e1
        @(negedge clk);              // after e1
        @(negedge clk);              // after e2
        sample_tick = 1'b1;          // strobe at e3
        @(posedge clk); #1;
        check(int'(err_out) == -32768, "R2 level unchanged before e3", int'(err_out), -32768);
        @(negedge clk);              // strobe held for e4
        @(posedge clk); #1;
        check(int'(err_out) == 4095 - 32768, "R2 first update seen at e4", int'(err_out), 4095 - 32768);
        check(err_valid == 1'b1, "R8 back-to-back valid", int'(err_valid), 1);
        @(negedge clk);
        sample_tick = 1'b0;
        @(posedge clk); #1;
        check(err_valid == 1'b0, "R9 valid drops", int'(err_valid), 0);
        check(int'(err_out) == 4095 - 32768, "R7 hold without strobe", int'(err_out), 4095 - 32768);
        cycles(20);
        check(int'(err_out) == 4095 - 32768, "R7 hold after many cycles", int'(err_out), 4095 - 32768);

        // R4 / R6: square waves at several phase offsets, periodic strobes
        for (int ph = 0; ph < 40; ph += 10) begin
            for (int t = 0; t < 2000; t++) begin
                @(negedge clk);
                zc_inv      = ((t % 40) < 20);
                zc_cap      = (((t + ph) % 40) < 20);
                sample_tick = ((t % 37) == 0) || ((t % 37) == 1);
            end
        end
        @(negedge clk);
        sample_tick = 1'b0;
        cycles(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule